// File: doc/BRIEF.md
# Multiplierless Interpolation Term Unit

This block forms the correction term (b − a)·n that a table interpolator adds to its lower table entry. The inputs are two neighbouring table values, a (`lo_val`) and b (`hi_val`), and a fractional position n (`frac_n`). The position is read as n/2^NW, so the result is the product scaled down by 2^NW. No multiplier is used. The unit takes the difference magnitude and the position into the log domain, adds the two logs, and converts the sum back to linear form.

Each log is built from a leading-one position, which gives the integer part, and the normalised bits below that one. A constant table, read twice in the same cycle, adds a correction for log2(1+f) − f to that fraction. A second constant table subtracts the error of the approximation 2^f ≈ 1 + f when the sum is converted back. A compare step decides whether b is above or below a. The output term is returned as a signed two's-complement value, so the next stage in the datapath always adds it.

The unit is a three-stage pipeline. It accepts one operand set per clock, marked by `in_valid`, and each result leaves with `out_valid`.

Top module: `log_interp_mul`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly three clock cycles. A new operand set is accepted on every cycle.
- R2: While `rst_n` is low, `out_valid` is 0 and `term` is 0.
- R3: `term` is 0 in every cycle in which `out_valid` is 0.
- R4: When `lo_val` equals `hi_val`, the result is exactly 0.
- R5: When `frac_n` is 0, the result is exactly 0, whatever the table values are.
- R6: A nonzero result is negative (two's complement, width DW+2) exactly when `lo_val` > `hi_val`, and positive exactly when `hi_val` > `lo_val`.
- R7: With d = |hi_val − lo_val|, the magnitude |term| satisfies 32·| |term|·2^NW − d·n | ≤ d·n + 32·2^NW.
- R8: When d and n are both powers of two, |term| equals (d·n) >> NW exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set present this cycle |
| lo_val | input | DW (12) | Table value a at index i, unsigned |
| hi_val | input | DW (12) | Table value b at index i+1, unsigned |
| frac_n | input | NW (7) | Fractional position n, unsigned, weight 2^-NW |
| out_valid | output | 1 | Result present this cycle |
| term | output | DW+2 (14) | Signed product (b − a)·n / 2^NW |

## Verification
Every result is due three rising edges after its operands are captured. The bench drives operands on the falling edge. It pushes its expected record into a queue that is held at three entries, and it pops one record on every falling edge, so each output is compared with the operands from exactly three cycles earlier. The comparison runs on every cycle, including idle cycles, where the bench expects zero and no valid flag. This covers the latency, the zero cases, the sign and the accuracy bound, with no single check that could land in the wrong cycle.

// File: rtl/log_interp_mul.sv
module log_interp_mul #(
  parameter int DW = 12,
  parameter int NW = 7,
  parameter int TB = 6,
  parameter int FB = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        lo_val,
  input  logic [DW-1:0]        hi_val,
  input  logic [NW-1:0]        frac_n,
  output logic                 out_valid,
  output logic signed [DW+1:0] term
);
  localparam int PB = $clog2(DW);
  localparam int LW = FB + $clog2(DW + 1);
  localparam int SW = LW + 1;
  localparam int IW = SW - FB;
  localparam int MW = DW + 1;
  localparam int PW = FB + 1 + DW + NW;
  localparam int Q  = 30;

  function automatic longint lg_fix(input longint y);
    longint x, r;
    x = (longint'(1) << Q) + (y << (Q - FB));
    r = 0;
    for (int j = 0; j < FB; j++) begin
      x = (x * x) >> Q;
      r = r << 1;
      if (x >= (longint'(2) << Q)) begin
        r = r | 1;
        x = x >> 1;
      end
    end
    return r;
  endfunction

  function automatic longint log_corr(input longint i);
    return lg_fix(i << (FB - TB)) - (i << (FB - TB));
  endfunction

  function automatic longint alog_corr(input longint i);
    longint x, lo, hi, mid;
    x  = i << (FB - TB);
    lo = 0;
    hi = (longint'(1) << FB) - 1;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (lg_fix(mid) <= x) lo = mid;
      else hi = mid - 1;
    end
    return (x > lo) ? x - lo : 0;
  endfunction

  function automatic logic [PB+FB-1:0] lod_norm(input logic [DW-1:0] x);
    logic [PB-1:0] p;
    logic [DW-1:0] sh;
    p = '0;
    for (int i = 0; i < DW; i++)
      if (x[i]) p = PB'(i);
    sh = x << (DW - 1 - int'(p));
    return {p, FB'({sh[DW-2:0], {FB{1'b0}}} >> (DW - 1))};
  endfunction

  logic [FB-1:0] lrom [2**TB];
  logic [FB-1:0] arom [2**TB];
  for (genvar g = 0; g < 2**TB; g++) begin : g_rom
    assign lrom[g] = FB'(log_corr(longint'(g)));
    assign arom[g] = FB'(alog_corr(longint'(g)));
  end

  logic          v1, neg1, z1;
  logic [DW-1:0] d1;
  logic [NW-1:0] n1;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; neg1 <= 1'b0; z1 <= 1'b0; d1 <= '0; n1 <= '0;
    end else begin
      v1   <= in_valid;
      neg1 <= lo_val > hi_val;
      d1   <= (lo_val > hi_val) ? lo_val - hi_val : hi_val - lo_val;
      z1   <= (lo_val == hi_val) || (frac_n == '0);
      n1   <= frac_n;
    end

  logic [PB+FB-1:0] nd, nn;
  logic [LW-1:0]    logd, logn;
  assign nd = lod_norm(d1);
  assign nn = lod_norm(DW'(n1));
  assign logd = LW'({nd[PB+FB-1:FB], {FB{1'b0}}}) + LW'(nd[FB-1:0]) + LW'(lrom[nd[FB-1 -: TB]]);
  assign logn = LW'({nn[PB+FB-1:FB], {FB{1'b0}}}) + LW'(nn[FB-1:0]) + LW'(lrom[nn[FB-1 -: TB]]);

  logic          v2, neg2, z2;
  logic [SW-1:0] sum2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v2 <= 1'b0; neg2 <= 1'b0; z2 <= 1'b0; sum2 <= '0;
    end else begin
      v2   <= v1;
      neg2 <= neg1;
      z2   <= z1;
      sum2 <= SW'(logd) + SW'(logn);
    end

  logic [IW-1:0] ip;
  logic [FB-1:0] fs;
  logic [FB:0]   mant;
  logic [MW-1:0] mag;
  assign ip   = sum2[SW-1:FB];
  assign fs   = sum2[FB-1:0];
  assign mant = {1'b1, fs} - (FB+1)'(arom[fs[FB-1 -: TB]]);
  assign mag  = MW'(({{(PW-FB-1){1'b0}}, mant} << ip) >> (FB + NW));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      term      <= '0;
    end else begin
      out_valid <= v2;
      if (!v2 || z2)  term <= '0;
      else if (neg2)  term <= -$signed({1'b0, mag});
      else            term <= $signed({1'b0, mag});
    end
endmodule

// File: rtl/log_interp_mul_chk.sv
module log_interp_mul_chk #(
  parameter int DW = 12,
  parameter int NW = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [DW-1:0]        lo_val,
  input logic [DW-1:0]        hi_val,
  input logic [NW-1:0]        frac_n,
  input logic                 out_valid,
  input logic signed [DW+1:0] term
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1
  AST_IDLE_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (term == '0)); // R3
  AST_EQUAL_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd3 && $past(in_valid && lo_val == hi_val, 3)) |-> (term == '0)); // R4
  AST_NPOS_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd3 && $past(in_valid && frac_n == '0, 3)) |-> (term == '0)); // R5
  AST_SIGN_NEG:    assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd3 && term < 0) |-> $past(lo_val > hi_val, 3)); // R6
  AST_SIGN_POS:    assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd3 && term > 0) |-> $past(hi_val > lo_val, 3)); // R6
endmodule

bind log_interp_mul log_interp_mul_chk #(.DW(DW), .NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lo_val(lo_val), .hi_val(hi_val),
  .frac_n(frac_n), .out_valid(out_valid), .term(term)
);

// File: tb/log_interp_mul_tb.sv
module log_interp_mul_tb_top;
  localparam int DW = 12;
  localparam int NW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] lo_val = '0, hi_val = '0;
  logic [NW-1:0] frac_n = '0;
  logic out_valid;
  logic signed [DW+1:0] term;

  always #4 clk = ~clk;

  log_interp_mul dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lo_val(lo_val), .hi_val(hi_val),
    .frac_n(frac_n), .out_valid(out_valid), .term(term)
  );

  typedef struct { bit v; longint a; longint b; longint n; } item_t;
  item_t pend[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic longint tval(int i);
    return (longint'(i) * 937 + longint'(i) * i * 13) % 4096;
  endfunction

  function automatic bit pow2(longint x);
    return x != 0 && (x & (x - 1)) == 0;
  endfunction

  task automatic check(string req, bit ok, longint got, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic check_item(item_t e);
    longint got, d, mag, err;
    got = longint'(term);
    check("R1", out_valid == e.v, longint'(out_valid), longint'(e.v));
    if (!e.v) begin
      check("R3", got == 0, got, 0);
      return;
    end
    d = (e.a > e.b) ? e.a - e.b : e.b - e.a;
    if (d == 0) begin
      check("R4", got == 0, got, 0);
      return;
    end
    if (e.n == 0) begin
      check("R5", got == 0, got, 0);
      return;
    end
    mag = (got < 0) ? -got : got;
    if (mag != 0)
      check("R6", (got < 0) == (e.a > e.b), got, (e.a > e.b) ? -1 : 1);
    if (pow2(d) && pow2(e.n)) begin
      check("R8", mag == ((d * e.n) >> NW), mag, (d * e.n) >> NW);
    end else begin
      err = mag * (longint'(1) << NW) - d * e.n;
      if (err < 0) err = -err;
      check("R7", err * 32 <= d * e.n + 32 * (longint'(1) << NW), mag, (d * e.n) >> NW);
    end
  endtask

  task automatic step(bit v, longint a, longint b, longint n);
    item_t e;
    @(negedge clk);
    check_item(pend.pop_front());
    in_valid = v;
    lo_val   = DW'(a);
    hi_val   = DW'(b);
    frac_n   = NW'(n);
    e.v = v; e.a = a; e.b = b; e.n = n;
    pend.push_back(e);
  endtask

  initial begin
    item_t idle;
    idle.v = 0; idle.a = 0; idle.b = 0; idle.n = 0;
    in_valid = 1'b1; lo_val = 12'd5; hi_val = 12'd900; frac_n = 7'd77;
    repeat (3) @(negedge clk);
    check("R2", out_valid == 1'b0, longint'(out_valid), 0);
    check("R2", term == '0, longint'(term), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) pend.push_back(idle);
    // R7 R6 R5 R4: sweep every table index against every position
    for (int i = 0; i < 64; i++)
      for (int n = 0; n < 128; n++)
        step(1, tval(i), tval(i + 1), n);
    // R8: powers of two in both directions
    for (int j = 0; j < DW; j++)
      for (int q = 0; q < NW; q++) begin
        step(1, 100, 100 + (longint'(1) << j) <= 4095 ? 100 + (longint'(1) << j) : (longint'(1) << j), longint'(1) << q);
        step(1, longint'(1) << j, 0, longint'(1) << q);
      end
    // R4 R1 R3: equal values with idle gaps between
    for (int k = 0; k < 20; k++) begin
      step(1, 37 * k, 37 * k, 5 * k + 1);
      step(0, 0, 4095, 127);
    end
    // R7: extreme operands
    step(1, 0, 4095, 127);
    step(1, 4095, 0, 127);
    step(1, 4095, 0, 1);
    step(1, 1, 0, 127);
    repeat (4) step(0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule